// File: doc/BRIEF.md
# Byte-Lane Bank Steering Unit

This unit sits between a byte-addressable requester with a 16-bit data path and a memory split into two 8-bit banks. The low bank holds every even byte address and drives lanes 7:0; the high bank holds every odd byte address and drives lanes 15:8. For each request (byte address, byte-or-word size, read-or-write, write data) it produces a high-byte-enable / address-bit-0 pair, one chip enable per bank, the bank address, a write strobe and the write data placed on the correct lanes. Read data coming back from the banks is reassembled so that the requester always sees the lower-addressed byte in bits 7:0.

A word at an even address moves in one bus cycle on both lanes. A word at an odd address straddles a bank pair: the unit splits it into two byte bus cycles, crossing the bytes between lanes, and reports completion once, after the second. Requests use a simple ready/valid handshake and finish with a one-cycle done pulse. The banks are assumed to be synchronous RAMs that return read data in the cycle after their enable.

Top module: `lane_steer_unit`

## Requirements
- R1: Out of reset the unit is ready, done is low, read data is zero and neither bank is enabled.
- R2: A word access at an even address N runs one bus cycle with high-byte-enable 0 and address bit 0 equal to 0, both banks enabled, bank address N[19:1], byte 7:0 of the write data on lanes 7:0 and byte 15:8 on lanes 15:8.
- R3: A byte access at an even address runs one bus cycle with high-byte-enable 1 and address bit 0 equal to 0, only the low bank enabled, and the write byte (bits 7:0) on lanes 7:0.
- R4: A byte access at an odd address runs one bus cycle with high-byte-enable 0 and address bit 0 equal to 1, only the high bank enabled, and the write byte (bits 7:0) on lanes 15:8.
- R5: A word access at an odd address N runs two bus cycles: first (0,1) with only the high bank at N[19:1] carrying write bits 7:0 on lanes 15:8, then (1,0) with only the low bank at (N+1)[19:1] carrying write bits 15:8 on lanes 7:0.
- R6: Each bus cycle lasts one clock and is followed by one capture clock; done pulses for exactly one clock, 3 clocks after the accepting edge for a single bus cycle and 5 for a split word, and ready is high during the done clock.
- R7: Read results hold the lower-addressed byte in bits 7:0 and, for a word, the next byte in bits 15:8; byte reads return zero in bits 15:8.
- R8: While a request is in progress, ready is low and any request presented is ignored: it causes no bus cycle and no memory change.
- R9: Bank enables follow the pair (high-byte-enable, address bit 0): (0,0) both banks, (0,1) high bank only, (1,0) low bank only, (1,1) none; outside bus cycles the pair is (1,1) and the write strobe is low.
- R10: A split word at the top byte address 0xFFFFF wraps, so its second bus cycle uses bank address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data, lower-addressed byte in bits 7:0 |
| req_ready | output | 1 | Unit idle, request accepted at this edge if valid |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Reassembled read data, valid with done |
| bus_bhe_n | output | 1 | High-byte enable, active low |
| bus_a0 | output | 1 | Address bit 0 / low-byte disable |
| bank_lo_en | output | 1 | Low (even) bank chip enable |
| bank_hi_en | output | 1 | High (odd) bank chip enable |
| bank_addr | output | 19 | Address within each bank |
| bank_we | output | 1 | Write strobe for enabled banks |
| bank_wdata | output | 16 | Lane-steered write data |
| bank_rdata | input | 16 | Data returned by the banks, lanes as above |

## Verification
The completion of one request and the acceptance of the next fall in the same clock: the done clock is also the idle clock in which a fresh request may be taken. The bench provokes this by presenting a new request in the done clock of the previous one, often after split words, and judges that the done pulse, the read data of the finished request and the first bus cycle of the new one all arrive in their expected clocks. It also offers stray requests during busy clocks and checks that bus cycles and memory contents stay those of the request in progress.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DRIVE = 2'd1,
      PH_LATCH = 2'd2
   } phase_t;

   localparam int BANKS = 2;

endpackage

// File: rtl/lsu_sequencer.sv
module lsu_sequencer
   import lsu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic split,
   output logic ready,
   output logic accept,
   output logic drive,
   output logic latch,
   output logic second,
   output logic done
);

   phase_t ph_q;
   logic   sec_q;
   logic   done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         sec_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (ph_q)
            PH_IDLE: begin
               if (req_valid) begin
                  ph_q  <= PH_DRIVE;
                  sec_q <= 1'b0;
               end
            end
            PH_DRIVE: ph_q <= PH_LATCH;
            PH_LATCH: begin
               if (split && !sec_q) begin
                  ph_q  <= PH_DRIVE;
                  sec_q <= 1'b1;
               end else begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign ready  = (ph_q == PH_IDLE);
   assign accept = ready & req_valid;
   assign drive  = (ph_q == PH_DRIVE);
   assign latch  = (ph_q == PH_LATCH);
   assign second = sec_q;
   assign done   = done_q;

endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
   import lsu_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int LANE_W = 8
) (
   input  logic                       drive,
   input  logic                       second,
   input  logic                       word,
   input  logic                       write,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [BANKS*LANE_W-1:0]    wdata,
   output logic                       bhe_n,
   output logic                       a0,
   output logic [BANKS-1:0]           lane_en,
   output logic [ADDR_W-2:0]          bank_addr,
   output logic                       we,
   output logic [BANKS*LANE_W-1:0]    lane_wdata
);

   localparam int DATA_W = BANKS * LANE_W;

   logic              split;
   logic [ADDR_W-1:0] cur;

   assign split = word & addr[0];
   assign cur   = addr + ADDR_W'(second);

   always_comb begin
      bhe_n = 1'b1;
      a0    = 1'b1;
      if (drive) begin
         if (split) begin
            bhe_n = second;
            a0    = ~second;
         end else if (word) begin
            bhe_n = 1'b0;
            a0    = 1'b0;
         end else begin
            bhe_n = ~addr[0];
            a0    = addr[0];
         end
      end
   end

   assign lane_en[0] = ~a0;
   assign lane_en[1] = ~bhe_n;
   assign bank_addr  = cur[ADDR_W-1:1];
   assign we         = drive & write;

   for (genvar i = 0; i < BANKS; i++) begin : g_lane
      logic take_hi;
      if (i == 0) begin : g_even
         assign take_hi = split & second;
      end else begin : g_odd
         assign take_hi = word & ~split;
      end
      assign lane_wdata[i*LANE_W +: LANE_W] =
         take_hi ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0];
   end

endmodule

// File: rtl/lsu_gather.sv
module lsu_gather
   import lsu_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    accept,
   input  logic                    latch,
   input  logic                    second,
   input  logic                    word,
   input  logic                    odd,
   input  logic                    write,
   input  logic [BANKS*LANE_W-1:0] bank_rdata,
   output logic [BANKS*LANE_W-1:0] rdata
);

   localparam int DATA_W = BANKS * LANE_W;

   logic [LANE_W-1:0] lo_lane;
   logic [LANE_W-1:0] hi_lane;

   assign lo_lane = bank_rdata[LANE_W-1:0];
   assign hi_lane = bank_rdata[DATA_W-1:LANE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (accept) begin
         rdata <= '0;
      end else if (latch && !write) begin
         if (!word) begin
            rdata <= {{LANE_W{1'b0}}, (odd ? hi_lane : lo_lane)};
         end else if (!odd) begin
            rdata <= bank_rdata;
         end else if (!second) begin
            rdata[LANE_W-1:0] <= hi_lane;
         end else begin
            rdata[DATA_W-1:LANE_W] <= lo_lane;
         end
      end
   end

endmodule

// File: rtl/lane_steer_unit.sv
module lane_steer_unit
   import lsu_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic                    req_word,
   input  logic                    req_write,
   input  logic [2*LANE_W-1:0]     req_wdata,
   output logic                    req_ready,
   output logic                    rsp_done,
   output logic [2*LANE_W-1:0]     rsp_rdata,
   output logic                    bus_bhe_n,
   output logic                    bus_a0,
   output logic                    bank_lo_en,
   output logic                    bank_hi_en,
   output logic [ADDR_W-2:0]       bank_addr,
   output logic                    bank_we,
   output logic [2*LANE_W-1:0]     bank_wdata,
   input  logic [2*LANE_W-1:0]     bank_rdata
);

   localparam int DATA_W = BANKS * LANE_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("lane_steer_unit: ADDR_W must be at least 2");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("lane_steer_unit: LANE_W must be at least 1");
   end

   logic [ADDR_W-1:0] addr_q;
   logic              word_q;
   logic              write_q;
   logic [DATA_W-1:0] wdata_q;

   logic              accept;
   logic              drive;
   logic              latch;
   logic              second;
   logic [BANKS-1:0]  lane_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         word_q  <= 1'b0;
         write_q <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         word_q  <= req_word;
         write_q <= req_write;
         wdata_q <= req_wdata;
      end
   end

   lsu_sequencer u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .split     (word_q & addr_q[0]),
      .ready     (req_ready),
      .accept    (accept),
      .drive     (drive),
      .latch     (latch),
      .second    (second),
      .done      (rsp_done)
   );

   lsu_lane_map #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W)
   ) u_map (
      .drive      (drive),
      .second     (second),
      .word       (word_q),
      .write      (write_q),
      .addr       (addr_q),
      .wdata      (wdata_q),
      .bhe_n      (bus_bhe_n),
      .a0         (bus_a0),
      .lane_en    (lane_en),
      .bank_addr  (bank_addr),
      .we         (bank_we),
      .lane_wdata (bank_wdata)
   );

   lsu_gather #(
      .LANE_W (LANE_W)
   ) u_gather (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .latch      (latch),
      .second     (second),
      .word       (word_q),
      .odd        (addr_q[0]),
      .write      (write_q),
      .bank_rdata (bank_rdata),
      .rdata      (rsp_rdata)
   );

   assign bank_lo_en = lane_en[0];
   assign bank_hi_en = lane_en[1];

endmodule

// File: rtl/lane_steer_unit_sva.sv
module lane_steer_unit_sva #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_done,
   input logic              bank_lo_en,
   input logic              bank_hi_en,
   input logic              bank_we,
   input logic [ADDR_W-2:0] bank_addr
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(bank_lo_en || bank_hi_en));

   assert_bus_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_lo_en || bank_hi_en) |=> !(bank_lo_en || bank_hi_en));

   assert_split_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_lo_en && !bank_hi_en && $past(bank_hi_en && !bank_lo_en, 2))
      |-> (bank_addr == $past(bank_addr, 2) + 1'b1));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);

   assert_write_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |-> (bank_lo_en || bank_hi_en));

endmodule

bind lane_steer_unit lane_steer_unit_sva #(.ADDR_W(ADDR_W)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_done   (rsp_done),
   .bank_lo_en (bank_lo_en),
   .bank_hi_en (bank_hi_en),
   .bank_we    (bank_we),
   .bank_addr  (bank_addr)
);

// File: tb/lane_steer_unit_test.sv
module lane_steer_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [19:0] req_addr = '0;
   logic        req_word = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic        bus_bhe_n;
   logic        bus_a0;
   logic        bank_lo_en;
   logic        bank_hi_en;
   logic [18:0] bank_addr;
   logic        bank_we;
   logic [15:0] bank_wdata;
   logic [15:0] bank_rdata;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   lane_steer_unit uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_word   (req_word),
      .req_write  (req_write),
      .req_wdata  (req_wdata),
      .req_ready  (req_ready),
      .rsp_done   (rsp_done),
      .rsp_rdata  (rsp_rdata),
      .bus_bhe_n  (bus_bhe_n),
      .bus_a0     (bus_a0),
      .bank_lo_en (bank_lo_en),
      .bank_hi_en (bank_hi_en),
      .bank_addr  (bank_addr),
      .bank_we    (bank_we),
      .bank_wdata (bank_wdata),
      .bank_rdata (bank_rdata)
   );

   function automatic logic [7:0] seed_byte(input int i);
      return 8'((i * 73) + 11);
   endfunction

   // bench banks: 512 bytes each, indexed by {bank_addr[18], bank_addr[7:0]}
   logic [7:0] ram_lo [512];
   logic [7:0] ram_hi [512];
   logic [7:0] rd_lo, rd_hi;
   logic [8:0] bix;
   assign bix = {bank_addr[18], bank_addr[7:0]};
   assign bank_rdata = {rd_hi, rd_lo};

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < 512; j++) begin
            ram_lo[j] = seed_byte({j[8:0], 1'b0});
            ram_hi[j] = seed_byte({j[8:0], 1'b1});
         end
         rd_lo <= '0;
         rd_hi <= '0;
      end else begin
         if (bank_lo_en) begin
            if (bank_we) ram_lo[bix] <= bank_wdata[7:0];
            else         rd_lo <= ram_lo[bix];
         end
         if (bank_hi_en) begin
            if (bank_we) ram_hi[bix] <= bank_wdata[15:8];
            else         rd_hi <= ram_hi[bix];
         end
      end
   end

   // reference byte memory, index {A[19], A[8:0]}
   logic [7:0] ref_mem [1024];

   function automatic logic [9:0] ri(input logic [19:0] x);
      return {x[19], x[8:0]};
   endfunction

   function automatic logic [19:0] rand_addr();
      logic [19:0] r;
      r = 20'($urandom) & 20'h001FF;
      if ($urandom % 2 == 1) r = r | 20'hFFE00;
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [19:0] a, input bit w, input bit wr,
                         input logic [15:0] d, input bit chained, input bit poke);
      bit          split;
      int          last;
      string       tg;
      logic [19:0] a1;
      logic [15:0] exp_rd;
      if (!chained) @(negedge clk);
      req_addr  = a;
      req_word  = w;
      req_write = wr;
      req_wdata = d;
      req_valid = 1'b1;
      chk(req_ready == 1'b1, "R6 ready before accept", 32'(req_ready), 32'd1);
      @(posedge clk);
      split = w & a[0];
      last  = split ? 5 : 3;
      a1    = a + 20'd1;
      tg    = split ? ((a == 20'hFFFFF) ? "R10" : "R5") : (w ? "R2" : (a[0] ? "R4" : "R3"));
      for (int k = 1; k <= last; k++) begin
         bit          drv;
         logic [3:0]  exp_sig;
         logic [18:0] exp_ba;
         logic [15:0] exp_wd;
         logic [15:0] mask;
         @(negedge clk);
         req_valid = 1'b0;
         if (poke && k < last) begin
            req_valid = 1'b1;
            req_addr  = rand_addr();
            req_write = 1'b1;
            req_word  = 1'($urandom);
            req_wdata = 16'($urandom);
         end
         drv = (k == 1) || (split && k == 3);
         exp_sig = 4'b0011;   // {lo_en, hi_en, bhe_n, a0}
         exp_ba  = a[19:1];
         exp_wd  = 16'h0;
         mask    = 16'h0;
         if (drv) begin
            if (split && k == 3) begin
               exp_sig = 4'b1010; exp_ba = a1[19:1];
               exp_wd = {8'h00, d[15:8]}; mask = 16'h00FF;
            end else if (split) begin
               exp_sig = 4'b0101; exp_wd = {d[7:0], 8'h00}; mask = 16'hFF00;
            end else if (w) begin
               exp_sig = 4'b1100; exp_wd = d; mask = 16'hFFFF;
            end else if (a[0]) begin
               exp_sig = 4'b0101; exp_wd = {d[7:0], 8'h00}; mask = 16'hFF00;
            end else begin
               exp_sig = 4'b1010; exp_wd = {8'h00, d[7:0]}; mask = 16'h00FF;
            end
         end
         chk({bank_lo_en, bank_hi_en, bus_bhe_n, bus_a0} == exp_sig,
             drv ? {tg, " enables/code (R9)"} : (poke ? "R8 busy request ignored" : "R9 idle code"),
             32'({bank_lo_en, bank_hi_en, bus_bhe_n, bus_a0}), 32'(exp_sig));
         chk(bank_we == (drv && wr), {tg, " write strobe"}, 32'(bank_we), 32'(drv && wr));
         if (drv) begin
            chk(bank_addr == exp_ba, {tg, " bank address"}, 32'(bank_addr), 32'(exp_ba));
            if (wr)
               chk((bank_wdata & mask) == exp_wd, {tg, " lane data"},
                   32'(bank_wdata & mask), 32'(exp_wd));
         end
         chk(rsp_done == (k == last), "R6 done timing", 32'(rsp_done), 32'(k == last));
         if (k == last)
            chk(req_ready == 1'b1, "R6 ready in done clock", 32'(req_ready), 32'd1);
      end
      if (!wr) begin
         exp_rd = w ? {ref_mem[ri(a1)], ref_mem[ri(a)]} : {8'h00, ref_mem[ri(a)]};
         chk(rsp_rdata == exp_rd, "R7 read data", 32'(rsp_rdata), 32'(exp_rd));
      end else begin
         ref_mem[ri(a)] = d[7:0];
         if (w) ref_mem[ri(a1)] = d[15:8];
      end
   endtask

   task automatic run_all();
      void'($urandom(32'd20240611));
      for (int i = 0; i < 1024; i++) ref_mem[i] = seed_byte(i);
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1 && rsp_done == 1'b0, "R1 ready/done after reset",
          32'({req_ready, rsp_done}), 32'b10);
      chk(!bank_lo_en && !bank_hi_en && bus_bhe_n && bus_a0, "R1 no bank enabled",
          32'({bank_lo_en, bank_hi_en, bus_bhe_n, bus_a0}), 32'b0011);
      chk(rsp_rdata == 16'h0, "R1 read data zero", 32'(rsp_rdata), 32'h0);

      // directed corners
      run_op(20'h00010, 1, 1, 16'hBEEF, 0, 0);   // R2 aligned word write
      run_op(20'h00010, 1, 0, 16'h0000, 0, 0);   // R2/R7 aligned read
      run_op(20'h00011, 0, 0, 16'h0000, 0, 0);   // R4/R7 odd byte read, upper zero
      run_op(20'h00021, 1, 1, 16'h1234, 0, 0);   // R5 split word write
      run_op(20'h00021, 0, 0, 16'h0000, 0, 0);   // R4 low byte lives in high bank
      run_op(20'h00022, 0, 0, 16'h0000, 0, 0);   // R3 high byte lives in low bank
      run_op(20'h00021, 1, 0, 16'h0000, 0, 0);   // R5/R7 split read
      run_op(20'h00030, 0, 1, 16'hFFA5, 0, 0);   // R3 even byte write
      run_op(20'h00031, 0, 1, 16'hEE5A, 0, 0);   // R4 odd byte write
      run_op(20'h00030, 1, 0, 16'h0000, 0, 0);   // R7
      run_op(20'hFFFFF, 1, 1, 16'hC3D2, 0, 0);   // R10 wrap write
      run_op(20'h00000, 0, 0, 16'h0000, 0, 0);   // R10 wrapped byte
      run_op(20'hFFFFF, 1, 0, 16'h0000, 0, 1);   // R10 wrap read, R8 stray requests
      run_op(20'h00041, 1, 1, 16'h7788, 0, 1);   // R8 busy pokes on split write
      run_op(20'h00041, 1, 0, 16'h0000, 1, 0);   // R6 accept in done clock
      run_op(20'h00040, 0, 0, 16'h0000, 1, 0);

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         bit ch;
         ch = (n != 0) && ($urandom % 10 < 3);
         run_op(rand_addr(), 1'($urandom), 1'($urandom), 16'($urandom), ch,
                ($urandom % 4 == 0));
      end
      // final sweep reads: R8 stray writes never landed
      for (int s = 0; s < 32; s++)
         run_op(rand_addr(), 1, 0, 16'h0000, 0, 0);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule